// File: doc/BRIEF.md
# Input-Line Brown-Out and Overvoltage Supervisor

This block decides whether the rectified input line is fit for a power converter to switch. It receives five comparator flags from an analog front end that watches a scaled copy of the line: above the turn-on level, above the turn-off level, above the enable level, above the line-overvoltage trip level and above the line-overvoltage release level. Its own state chooses which undervoltage flag counts. A brown-out is declared only after the line has stayed low for a qualifying time. A line overvoltage is declared only after a blanking time. Both faults stop switching.

When the line returns from a brown-out, the block sends a one-cycle general reset that releases latched protections elsewhere in the controller. Switching does not resume straight away. A restart grant is given only on the next supply turn-on event, or at once if the supply already sits above its turn-on level. Every grant comes with a one-cycle soft-start request. When the supply crosses its minimum level for the first time after a supply logic reset, the block samples the enable flag once. If the monitor pin is held near ground at that moment, every function of the block is switched off until the next supply logic reset.

Timer lengths are given in clock cycles as parameters (`UV_CYC` for the undervoltage filter, `OV_CYC` for the overvoltage blanking). The time base is the block clock.

Top module: `line_supervisor`

## Requirements
- R1: After reset `not_ok` is 1, and `restart_grant`, `gen_reset` and `ss_req` are 0.
- R2: While a brown-out is declared, only `cmp_above_on`=1 ends it, and `cmp_above_off`=1 alone keeps `not_ok` at 1. While no brown-out is declared, only `cmp_above_off`=0 can start one, and `cmp_above_on`=0 alone has no effect.
- R3: A brown-out is declared when `cmp_above_off` is 0 at `UV_CYC` consecutive rising edges. `not_ok` becomes 1 after the `UV_CYC`-th edge, and `restart_grant` falls with it.
- R4: A single edge with `cmp_above_off`=1 restarts the undervoltage count from zero, so a low run shorter than `UV_CYC` edges leaves `not_ok` at 0.
- R5: The edge that ends a brown-out raises `gen_reset` for exactly one cycle. The end of a line overvoltage raises no `gen_reset`.
- R6: When all faults clear, `restart_grant` rises at that same edge if `vcc_above_on`=1. Otherwise it stays 0 until an edge with `vcc_on_evt`=1 and rises there.
- R7: `ss_req` is 1 for exactly the first cycle of each period in which `restart_grant` is 1.
- R8: A line overvoltage is declared when `cmp_ovp_on` is 1 at `OV_CYC` consecutive edges. A shorter run has no effect.
- R9: A declared line overvoltage holds while `cmp_ovp_off`=1 and clears at the first edge with `cmp_ovp_off`=0.
- R10: At the first `vcc_min_cross` pulse after reset or `supply_rst`, `cmp_above_en`=0 disables the block. `not_ok` is then 0, the restart path grants as in R6, and every comparator flag is ignored. With `cmp_above_en`=1 the block stays enabled. Later pulses are not sampled.
- R11: The disabled state is held until `supply_rst`. `supply_rst` sets `not_ok` to 1, clears `restart_grant` and re-arms the enable check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, also the timer base |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_above_on | input | 1 | Line above the turn-on level |
| cmp_above_off | input | 1 | Line above the turn-off level |
| cmp_above_en | input | 1 | Line above the enable level |
| cmp_ovp_on | input | 1 | Line above the overvoltage trip level |
| cmp_ovp_off | input | 1 | Line above the overvoltage release level |
| vcc_min_cross | input | 1 | One-cycle pulse when the supply crosses its minimum level |
| vcc_on_evt | input | 1 | One-cycle pulse when the supply reaches its turn-on level |
| vcc_above_on | input | 1 | Supply currently above its turn-on level |
| supply_rst | input | 1 | Supply logic reset pulse |
| not_ok | output | 1 | Line fault active; switching must stop |
| gen_reset | output | 1 | One-cycle general reset on brown-out recovery |
| restart_grant | output | 1 | Switching permitted |
| ss_req | output | 1 | One-cycle soft-start request when switching is granted |

## Verification
The hardest cases to reach are the exact ends of the filter windows. A low run of `UV_CYC-1` edges must leave the line accepted, and a run of `UV_CYC` edges must declare a brown-out. The bench reaches both by sweeping every run length from one to the window length, for both the undervoltage and the overvoltage timers, with a separating edge between runs. The disabled state is just as awkward, because it can only be entered at one moment. The bench reaches it by issuing a supply reset, then a minimum-level crossing with the enable flag low. It then checks that a second crossing with the flag high is ignored, and that only another supply reset re-arms the check.

// File: rtl/line_sup_pkg.sv
package line_sup_pkg;
  typedef struct packed {
    logic on;
    logic off;
    logic en;
    logic ovp_on;
    logic ovp_off;
  } line_cmp_t;
endpackage

// File: rtl/line_win_filter.sv
module line_win_filter #(
  parameter int CYC = 50
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic cond,
  output logic expire
);
  localparam int CW = (CYC < 2) ? 1 : $clog2(CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d  = cnt_q;
    expire = 1'b0;
    if (clr || !cond) begin
      cnt_d = '0;
    end else if (cnt_q == CW'(CYC - 1)) begin
      cnt_d  = '0;
      expire = 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  AST_WIN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(CYC)); // R3

  AST_WIN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !cond |=> cnt_q == '0); // R4
endmodule

// File: rtl/line_en_check.sv
module line_en_check (
  input  logic clk,
  input  logic rst_n,
  input  logic supply_rst,
  input  logic min_cross,
  input  logic above_en,
  output logic dis_q,
  output logic dis_d
);
  logic done_q, done_d;

  always_comb begin
    dis_d  = dis_q;
    done_d = done_q;
    if (supply_rst) begin
      dis_d  = 1'b0;
      done_d = 1'b0;
    end else if (min_cross && !done_q) begin
      dis_d  = !above_en;
      done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dis_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      dis_q  <= dis_d;
      done_q <= done_d;
    end
  end

  AST_DIS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    dis_q && !supply_rst |=> dis_q); // R11
endmodule

// File: rtl/line_restart_sync.sv
module line_restart_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic fault_q,
  input  logic fault_d,
  input  logic vcc_above_on,
  input  logic vcc_on_evt,
  output logic grant_q,
  output logic ss_q
);
  logic pend_q, pend_d, grant_d, ss_d;

  always_comb begin
    grant_d = grant_q;
    pend_d  = pend_q;
    if (fault_d) begin
      grant_d = 1'b0;
      pend_d  = 1'b0;
    end else if (fault_q) begin
      if (vcc_above_on) grant_d = 1'b1;
      else              pend_d  = 1'b1;
    end else if (pend_q && vcc_on_evt) begin
      grant_d = 1'b1;
      pend_d  = 1'b0;
    end
    ss_d = grant_d && !grant_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= 1'b0;
      pend_q  <= 1'b0;
      ss_q    <= 1'b0;
    end else begin
      grant_q <= grant_d;
      pend_q  <= pend_d;
      ss_q    <= ss_d;
    end
  end

  AST_SS_WITH_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    ss_q |-> grant_q); // R7
  AST_SS_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    ss_q |=> !ss_q); // R7
  AST_PEND_NO_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> !grant_q); // R6
endmodule

// File: rtl/line_supervisor.sv
module line_supervisor #(
  parameter int UV_CYC = 50,
  parameter int OV_CYC = 20
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmp_above_on,
  input  logic cmp_above_off,
  input  logic cmp_above_en,
  input  logic cmp_ovp_on,
  input  logic cmp_ovp_off,
  input  logic vcc_min_cross,
  input  logic vcc_on_evt,
  input  logic vcc_above_on,
  input  logic supply_rst,
  output logic not_ok,
  output logic gen_reset,
  output logic restart_grant,
  output logic ss_req
);
  import line_sup_pkg::*;

  line_cmp_t cmp;
  logic dis_q, dis_d;
  logic bo_nok_q, bo_nok_d, ov_q, ov_d, gen_q, gen_d;
  logic level_ok, uv_cond, ov_cond, bo_recover, uv_exp, ov_exp;
  logic fault_q, fault_d, filt_clr;

  assign cmp = '{on: cmp_above_on, off: cmp_above_off, en: cmp_above_en,
                 ovp_on: cmp_ovp_on, ovp_off: cmp_ovp_off};

  line_en_check u_en (
    .clk(clk), .rst_n(rst_n), .supply_rst(supply_rst),
    .min_cross(vcc_min_cross), .above_en(cmp.en),
    .dis_q(dis_q), .dis_d(dis_d)
  );

  always_comb begin
    level_ok   = bo_nok_q ? cmp.on : cmp.off;
    uv_cond    = !dis_q && !bo_nok_q && !level_ok;
    bo_recover = !dis_q && bo_nok_q && level_ok;
    ov_cond    = !dis_q && !ov_q && cmp.ovp_on;
    filt_clr   = supply_rst || dis_q;
  end

  line_win_filter #(.CYC(UV_CYC)) u_uv (
    .clk(clk), .rst_n(rst_n), .clr(filt_clr), .cond(uv_cond), .expire(uv_exp)
  );

  line_win_filter #(.CYC(OV_CYC)) u_ov (
    .clk(clk), .rst_n(rst_n), .clr(filt_clr), .cond(ov_cond), .expire(ov_exp)
  );

  always_comb begin
    bo_nok_d = bo_nok_q;
    ov_d     = ov_q;
    if (supply_rst) begin
      bo_nok_d = 1'b1;
      ov_d     = 1'b0;
    end else if (dis_q) begin
      bo_nok_d = 1'b0;
      ov_d     = 1'b0;
    end else begin
      if (uv_exp)          bo_nok_d = 1'b1;
      else if (bo_recover) bo_nok_d = 1'b0;
      if (ov_exp)                  ov_d = 1'b1;
      else if (ov_q && !cmp.ovp_off) ov_d = 1'b0;
    end
    gen_d   = !supply_rst && bo_recover;
    fault_q = !dis_q && (bo_nok_q || ov_q);
    fault_d = !dis_d && (bo_nok_d || ov_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bo_nok_q <= 1'b1;
      ov_q     <= 1'b0;
      gen_q    <= 1'b0;
    end else begin
      bo_nok_q <= bo_nok_d;
      ov_q     <= ov_d;
      gen_q    <= gen_d;
    end
  end

  line_restart_sync u_rs (
    .clk(clk), .rst_n(rst_n), .fault_q(fault_q), .fault_d(fault_d),
    .vcc_above_on(vcc_above_on), .vcc_on_evt(vcc_on_evt),
    .grant_q(restart_grant), .ss_q(ss_req)
  );

  assign not_ok    = fault_q;
  assign gen_reset = gen_q;

  AST_GRANT_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    not_ok |-> !restart_grant); // R6
  AST_GENRST_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    gen_reset |=> !gen_reset); // R5
  AST_GENRST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    gen_reset |-> $past(bo_nok_q) && !bo_nok_q); // R5
  AST_DIS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    dis_q |-> !not_ok && !gen_reset); // R10
endmodule

// File: tb/line_supervisor_tb.sv
module line_supervisor_tb;
  localparam int UV = 5;
  localparam int OV = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic on_i, off_i, en_i, ovon_i, ovoff_i, minx_i, vevt_i, vabove_i, srst_i;
  logic not_ok, gen_reset, restart_grant, ss_req;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  line_supervisor #(.UV_CYC(UV), .OV_CYC(OV)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmp_above_on(on_i), .cmp_above_off(off_i),
    .cmp_above_en(en_i), .cmp_ovp_on(ovon_i), .cmp_ovp_off(ovoff_i),
    .vcc_min_cross(minx_i), .vcc_on_evt(vevt_i), .vcc_above_on(vabove_i),
    .supply_rst(srst_i), .not_ok(not_ok), .gen_reset(gen_reset),
    .restart_grant(restart_grant), .ss_req(ss_req)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  initial begin
    #1500000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    {on_i, off_i, en_i, ovon_i, ovoff_i, minx_i, vevt_i, srst_i} = '0;
    vabove_i = 1'b1;
    en_i = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    chk("R1", "not_ok", not_ok, 1'b1);
    chk("R1", "grant", restart_grant, 1'b0);
    chk("R1", "gen_reset", gen_reset, 1'b0);
    chk("R1", "ss_req", ss_req, 1'b0);

    // enable check with enable flag high
    minx_i = 1'b1; tick(); minx_i = 1'b0;
    chk("R10", "stays enabled not_ok", not_ok, 1'b1);

    // R2: off flag high alone does not end the brown-out
    off_i = 1'b1;
    repeat (3) tick();
    chk("R2", "off alone keeps not_ok", not_ok, 1'b1);

    // recovery with supply above turn-on: immediate grant
    on_i = 1'b1; tick();
    chk("R5", "gen_reset pulse", gen_reset, 1'b1);
    chk("R6", "immediate grant", restart_grant, 1'b1);
    chk("R7", "ss_req with grant", ss_req, 1'b1);
    chk("R2", "not_ok cleared by on", not_ok, 1'b0);
    tick();
    chk("R5", "gen_reset one cycle", gen_reset, 1'b0);
    chk("R7", "ss_req one cycle", ss_req, 1'b0);

    // R2: on flag low alone has no effect while line accepted
    on_i = 1'b0;
    repeat (UV + 3) tick();
    chk("R2", "on low ignored", not_ok, 1'b0);

    // R3/R4 sweep of undervoltage run lengths
    for (int k = 1; k <= UV; k++) begin
      off_i = 1'b0;
      repeat (k) tick();
      chk((k >= UV) ? "R3" : "R4", $sformatf("uv run %0d not_ok", k), not_ok, (k >= UV));
      chk((k >= UV) ? "R3" : "R4", $sformatf("uv run %0d grant", k), restart_grant, (k < UV));
      off_i = 1'b1;
      tick();
      if (k >= UV) begin
        chk("R2", "off high keeps brown-out", not_ok, 1'b1);
        // recovery with delayed supply turn-on
        vabove_i = 1'b0;
        on_i = 1'b1; tick();
        chk("R5", "gen_reset on recovery", gen_reset, 1'b1);
        chk("R6", "grant waits", restart_grant, 1'b0);
        repeat (3) tick();
        chk("R6", "still waiting", restart_grant, 1'b0);
        chk("R7", "no ss while waiting", ss_req, 1'b0);
        vevt_i = 1'b1; tick(); vevt_i = 1'b0;
        chk("R6", "grant at turn-on event", restart_grant, 1'b1);
        chk("R7", "ss at delayed grant", ss_req, 1'b1);
        vabove_i = 1'b1;
        on_i = 1'b0;
        tick();
      end else begin
        chk("R4", "uv counter restarted", not_ok, 1'b0);
      end
    end

    // R8/R9 sweep of overvoltage run lengths
    ovoff_i = 1'b1;
    for (int k = 1; k <= OV; k++) begin
      ovon_i = 1'b1;
      repeat (k) tick();
      chk("R8", $sformatf("ov run %0d not_ok", k), not_ok, (k >= OV));
      ovon_i = 1'b0;
      tick();
      if (k >= OV) begin
        repeat (2) tick();
        chk("R9", "ov held above release", not_ok, 1'b1);
        ovoff_i = 1'b0; tick();
        chk("R9", "ov cleared", not_ok, 1'b0);
        chk("R5", "no gen_reset after ov", gen_reset, 1'b0);
        chk("R6", "grant after ov", restart_grant, 1'b1);
        chk("R7", "ss after ov", ss_req, 1'b1);
      end else begin
        chk("R8", "short ov ignored", not_ok, 1'b0);
      end
    end

    // R10: supply reset then disable at first crossing
    srst_i = 1'b1; tick(); srst_i = 1'b0;
    chk("R11", "supply_rst not_ok", not_ok, 1'b1);
    chk("R11", "supply_rst grant", restart_grant, 1'b0);
    on_i = 1'b0; off_i = 1'b0; en_i = 1'b0;
    minx_i = 1'b1; tick(); minx_i = 1'b0;
    chk("R10", "disabled not_ok", not_ok, 1'b0);
    chk("R10", "disabled grant", restart_grant, 1'b1);
    ovon_i = 1'b1; ovoff_i = 1'b1;
    repeat (UV + OV + 2) tick();
    chk("R10", "flags ignored", not_ok, 1'b0);
    chk("R10", "no gen_reset when disabled", gen_reset, 1'b0);
    en_i = 1'b1;
    minx_i = 1'b1; tick(); minx_i = 1'b0;
    repeat (UV + 2) tick();
    chk("R11", "second crossing not sampled", not_ok, 1'b0);
    ovon_i = 1'b0; ovoff_i = 1'b0;

    // R11: supply reset re-arms check, enabled this time
    srst_i = 1'b1; tick(); srst_i = 1'b0;
    chk("R11", "rearm not_ok", not_ok, 1'b1);
    minx_i = 1'b1; tick(); minx_i = 1'b0;
    repeat (3) tick();
    chk("R11", "enabled after rearm", not_ok, 1'b1);
    on_i = 1'b1; off_i = 1'b1; tick();
    chk("R11", "recovers after rearm", not_ok, 1'b0);
    chk("R5", "gen_reset after rearm", gen_reset, 1'b1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule